// File: doc/BRIEF.md
# Address-Correlating Successor Prefetcher

The block watches a stream of load addresses (optionally only those that missed in the cache) and learns which address tends to come next after a given key. The key is either the current address or, in history mode, the XOR of the current address with the previous accepted addresses. A direct-mapped, tagged table holds one entry per key. Each entry keeps a few successor candidates, and each candidate has a saturating confidence counter. Every accepted access first trains the entry of the previous key with the new address. It then looks up the entry of the new key and queues prefetch requests for its confident candidates, the strongest first.

Control is a three-state machine. ST_IDLE waits for an access. A kept access moves to ST_TRAIN, and a filtered one stays in ST_IDLE. ST_TRAIN always moves on to ST_EMIT. ST_EMIT stays while an unissued eligible candidate remains, pushing one request per cycle, and returns to ST_IDLE when none is left. Requests leave through a small queue with a valid/ready handshake. A request produced while the queue is full is dropped.

Top module: `corr_prefetch`

## Requirements
- R1: After reset, pf_valid is 0, acc_ready is 1 and every table entry and history register is empty.
- R2: In address mode the key is the access address. The low log2(SETS) bits select the entry and the remaining bits form its tag.
- R3: An accepted access trains the entry of the previous kept access's key. An unseen successor is stored with confidence 1.
- R4: When the successor matches a stored candidate, that candidate's confidence rises by 1, saturating at 3. Every other valid candidate in the entry falls by 1, stopping at 0.
- R5: A successor that is not stored replaces the candidate with the lowest confidence; an empty slot counts as 0 and ties go to the lower slot. The other candidates are left unchanged.
- R6: When the training entry's tag differs from the previous key's tag, the entry is reallocated. It takes the new tag, all candidates are cleared, and the successor goes in slot 0 with confidence 1.
- R7: On a tag hit, each candidate whose confidence is at least conf_thresh is requested once, in descending confidence order, with ties to the lower slot. A tag miss requests nothing.
- R8: When hist_mode is 1, the key is the XOR of the current address with the previous HIST_K-1 kept addresses (default: the one before).
- R9: When miss_only is 1, an access with acc_miss 0 is accepted but ignored. It trains nothing, requests nothing and leaves the history unchanged, and acc_ready stays 1.
- R10: The request queue holds QDEPTH (4) requests. pf_addr is held stable while pf_valid is 1 and pf_ready is 0, and requests produced while it is full are dropped.
- R11: A kept access is taken on the edge where acc_valid and acc_ready are both 1. acc_ready is 0 from the next cycle until the emission ends. The first request is pushed on the second edge after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access address offered |
| acc_ready | output | 1 | Block is idle and takes the access |
| acc_addr | input | ADDR_W | Load address |
| acc_miss | input | 1 | Access missed in the cache |
| miss_only | input | 1 | Learn only from missing accesses |
| hist_mode | input | 1 | Key from XOR of recent addresses |
| conf_thresh | input | CONF_W | Minimum confidence to prefetch |
| pf_valid | output | 1 | Prefetch request available |
| pf_ready | input | 1 | Consumer takes the request |
| pf_addr | output | ADDR_W | Prefetch address |

## Verification
An accepted access lowers acc_ready on the next edge. Training lands on the edge after that, and the first request is pushed on the second edge after acceptance; further requests follow one per cycle. A filtered access leaves acc_ready high on the next cycle. The bench therefore changes inputs only at falling edges and checks acc_ready one cycle after the offer. It collects requests at falling edges while it waits for acc_ready to return, then waits three more cycles before comparing their count and order. In the queue test the consumer is stalled across several accesses and the drain count is compared afterwards.

// File: rtl/corr_pf_pkg.sv
package corr_pf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRAIN = 2'd1,
        ST_EMIT  = 2'd2
    } pf_state_e;

endpackage

// File: rtl/corr_hist_key.sv
module corr_hist_key #(
    parameter int ADDR_W = 16,
    parameter int HIST_K = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              hist_mode,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] key
);

    generate
        if (HIST_K > 1) begin : g_hist
            localparam int PAST_N = HIST_K - 1;
            logic [ADDR_W-1:0] past_q [PAST_N];

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < PAST_N; i++) past_q[i] <= '0;
                end else if (adv) begin
                    past_q[0] <= addr;
                    for (int i = 1; i < PAST_N; i++) past_q[i] <= past_q[i-1];
                end
            end

            always_comb begin
                key = addr;
                if (hist_mode) begin
                    for (int i = 0; i < PAST_N; i++) key = key ^ past_q[i];
                end
            end
        end else begin : g_plain
            assign key = addr;
        end
    endgenerate

endmodule

// File: rtl/corr_table.sv
module corr_table #(
    parameter int ADDR_W    = 16,
    parameter int SETS      = 8,
    parameter int NCAND     = 2,
    parameter int CONF_W    = 2,
    parameter int CONF_INIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              train_en,
    input  logic [ADDR_W-1:0] train_key,
    input  logic [ADDR_W-1:0] train_succ,
    input  logic [ADDR_W-1:0] sel_key,
    input  logic [CONF_W-1:0] thresh,
    input  logic [NCAND-1:0]  emit_mask,
    output logic              sel_found,
    output logic [(NCAND > 1 ? $clog2(NCAND) : 1)-1:0] sel_slot,
    output logic [ADDR_W-1:0] sel_addr
);

    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int CIDX_W = (NCAND > 1) ? $clog2(NCAND) : 1;
    localparam logic [CONF_W-1:0] CONF_MAX = {CONF_W{1'b1}};
    localparam logic [CONF_W-1:0] CONF_NEW = CONF_W'(CONF_INIT);

    logic              ent_vld_q [SETS];
    logic [TAG_W-1:0]  ent_tag_q [SETS];
    logic              cv_q [SETS][NCAND];
    logic [ADDR_W-1:0] ca_q [SETS][NCAND];
    logic [CONF_W-1:0] cc_q [SETS][NCAND];

    logic [IDX_W-1:0]  t_idx, s_idx;
    logic [TAG_W-1:0]  t_tag, s_tag;
    logic              t_hit, s_hit, any_m;
    logic [NCAND-1:0]  m_vec;
    logic [CIDX_W-1:0] victim;
    logic [CONF_W-1:0] v_conf, eff, best;

    assign t_idx = train_key[IDX_W-1:0];
    assign t_tag = train_key[ADDR_W-1:IDX_W];
    assign s_idx = sel_key[IDX_W-1:0];
    assign s_tag = sel_key[ADDR_W-1:IDX_W];

    // training side: tag check, match vector, weakest slot
    always_comb begin
        t_hit  = ent_vld_q[t_idx] && (ent_tag_q[t_idx] == t_tag);
        m_vec  = '0;
        any_m  = 1'b0;
        victim = '0;
        v_conf = cv_q[t_idx][0] ? cc_q[t_idx][0] : '0;
        eff    = '0;
        for (int i = 0; i < NCAND; i++) begin
            m_vec[i] = cv_q[t_idx][i] && (ca_q[t_idx][i] == train_succ);
            any_m    = any_m | m_vec[i];
        end
        for (int i = 1; i < NCAND; i++) begin
            eff = cv_q[t_idx][i] ? cc_q[t_idx][i] : '0;
            if (eff < v_conf) begin
                v_conf = eff;
                victim = CIDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                ent_vld_q[s] <= 1'b0;
                ent_tag_q[s] <= '0;
                for (int i = 0; i < NCAND; i++) begin
                    cv_q[s][i] <= 1'b0;
                    ca_q[s][i] <= '0;
                    cc_q[s][i] <= '0;
                end
            end
        end else if (train_en) begin
            if (!t_hit) begin
                ent_vld_q[t_idx] <= 1'b1;
                ent_tag_q[t_idx] <= t_tag;
                for (int i = 0; i < NCAND; i++) begin
                    cv_q[t_idx][i] <= (i == 0);
                    ca_q[t_idx][i] <= train_succ;
                    cc_q[t_idx][i] <= (i == 0) ? CONF_NEW : '0;
                end
            end else if (any_m) begin
                for (int i = 0; i < NCAND; i++) begin
                    if (m_vec[i]) begin
                        if (cc_q[t_idx][i] != CONF_MAX) cc_q[t_idx][i] <= cc_q[t_idx][i] + 1'b1;
                    end else if (cv_q[t_idx][i] && cc_q[t_idx][i] != '0) begin
                        cc_q[t_idx][i] <= cc_q[t_idx][i] - 1'b1;
                    end
                end
            end else begin
                cv_q[t_idx][victim] <= 1'b1;
                ca_q[t_idx][victim] <= train_succ;
                cc_q[t_idx][victim] <= CONF_NEW;
            end
        end
    end

    // lookup side: strongest eligible candidate not yet issued
    always_comb begin
        s_hit     = ent_vld_q[s_idx] && (ent_tag_q[s_idx] == s_tag);
        sel_found = 1'b0;
        sel_slot  = '0;
        sel_addr  = '0;
        best      = '0;
        for (int i = 0; i < NCAND; i++) begin
            if (s_hit && cv_q[s_idx][i] && (cc_q[s_idx][i] >= thresh) && !emit_mask[i]
                && (!sel_found || cc_q[s_idx][i] > best)) begin
                sel_found = 1'b1;
                sel_slot  = CIDX_W'(i);
                sel_addr  = ca_q[s_idx][i];
                best      = cc_q[s_idx][i];
            end
        end
    end

endmodule

// File: rtl/corr_pf_queue.sv
module corr_pf_queue #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready
);

    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [PTR_W:0]   cnt_q;
    logic             full, do_push, do_pop;

    assign full      = (cnt_q == (PTR_W+1)'(DEPTH));
    assign out_valid = (cnt_q != '0);
    assign out_data  = mem_q[rd_q];
    assign do_push   = push && !full;
    assign do_pop    = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (do_push) begin
                mem_q[wr_q] <= push_data;
                wr_q        <= wr_q + 1'b1;
            end
            if (do_pop) rd_q <= rd_q + 1'b1;
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/corr_prefetch.sv
module corr_prefetch
    import corr_pf_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int SETS      = 8,
    parameter int NCAND     = 2,
    parameter int CONF_W    = 2,
    parameter int CONF_INIT = 1,
    parameter int HIST_K    = 2,
    parameter int QDEPTH    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    output logic              acc_ready,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_miss,
    input  logic              miss_only,
    input  logic              hist_mode,
    input  logic [CONF_W-1:0] conf_thresh,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);

    localparam int CIDX_W = (NCAND > 1) ? $clog2(NCAND) : 1;

    pf_state_e         state_q, state_d;
    logic              keep, train_en, push;
    logic [ADDR_W-1:0] new_key;
    logic [ADDR_W-1:0] cur_addr_q, look_key_q, train_key_q, prev_key_q;
    logic              train_go_q, prev_vld_q;
    logic [NCAND-1:0]  emit_mask_q;
    logic              sel_found;
    logic [CIDX_W-1:0] sel_slot;
    logic [ADDR_W-1:0] sel_addr;

    corr_hist_key #(.ADDR_W(ADDR_W), .HIST_K(HIST_K)) u_key (
        .clk(clk), .rst_n(rst_n), .adv(keep), .hist_mode(hist_mode),
        .addr(acc_addr), .key(new_key)
    );

    corr_table #(
        .ADDR_W(ADDR_W), .SETS(SETS), .NCAND(NCAND),
        .CONF_W(CONF_W), .CONF_INIT(CONF_INIT)
    ) u_tbl (
        .clk(clk), .rst_n(rst_n), .train_en(train_en),
        .train_key(train_key_q), .train_succ(cur_addr_q),
        .sel_key(look_key_q), .thresh(conf_thresh), .emit_mask(emit_mask_q),
        .sel_found(sel_found), .sel_slot(sel_slot), .sel_addr(sel_addr)
    );

    corr_pf_queue #(.W(ADDR_W), .DEPTH(QDEPTH)) u_q (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(sel_addr),
        .out_valid(pf_valid), .out_data(pf_addr), .out_ready(pf_ready)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (keep) state_d = ST_TRAIN;
            ST_TRAIN: state_d = ST_EMIT;
            ST_EMIT:  if (!sel_found) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs of the state machine
    always_comb begin
        acc_ready = 1'b0;
        keep      = 1'b0;
        train_en  = 1'b0;
        push      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                acc_ready = 1'b1;
                keep      = acc_valid && (!miss_only || acc_miss);
            end
            ST_TRAIN: train_en = train_go_q;
            ST_EMIT:  push     = sel_found;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_q  <= '0;
            look_key_q  <= '0;
            train_key_q <= '0;
            prev_key_q  <= '0;
            train_go_q  <= 1'b0;
            prev_vld_q  <= 1'b0;
            emit_mask_q <= '0;
        end else if (keep) begin
            cur_addr_q  <= acc_addr;
            look_key_q  <= new_key;
            train_key_q <= prev_key_q;
            train_go_q  <= prev_vld_q;
            prev_key_q  <= new_key;
            prev_vld_q  <= 1'b1;
            emit_mask_q <= '0;
        end else if (push) begin
            emit_mask_q[sel_slot] <= 1'b1;
        end
    end

endmodule

// File: rtl/corr_prefetch_chk.sv
module corr_prefetch_chk
    import corr_pf_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NCAND  = 2,
    parameter int CIDX_W = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_ready,
    input logic              acc_miss,
    input logic              miss_only,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr,
    input pf_state_e         state,
    input logic              sel_found,
    input logic [CIDX_W-1:0] sel_slot,
    input logic [NCAND-1:0]  emit_mask
);

    a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_ready && (!miss_only || acc_miss) |=> !acc_ready);

    a_r9_filtered_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_ready && miss_only && !acc_miss |=> acc_ready);

    a_r7_no_repeat_slot: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_EMIT && sel_found |-> !emit_mask[sel_slot]);

    a_r11_train_then_emit: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_TRAIN |=> state == ST_EMIT);

endmodule

bind corr_prefetch corr_prefetch_chk #(
    .ADDR_W(ADDR_W), .NCAND(NCAND), .CIDX_W(CIDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_miss(acc_miss), .miss_only(miss_only), .pf_valid(pf_valid),
    .pf_ready(pf_ready), .pf_addr(pf_addr), .state(state_q),
    .sel_found(sel_found), .sel_slot(sel_slot), .emit_mask(emit_mask_q)
);

// File: tb/corr_prefetch_bench.sv
`timescale 1ns/1ps
module corr_prefetch_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_ready;
    logic [15:0] acc_addr = '0;
    logic        acc_miss = 1'b0;
    logic        miss_only = 1'b0;
    logic        hist_mode = 1'b0;
    logic [1:0]  conf_thresh = 2'd1;
    logic        pf_valid;
    logic        pf_ready = 1'b1;
    logic [15:0] pf_addr;

    int          n_cmp = 0;
    int          n_bad = 0;
    int          n_got = 0;
    int          cyc = 0;
    logic [15:0] got [8];

    always #4 clk = ~clk;

    corr_prefetch u_corr_prefetch (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
        .acc_addr(acc_addr), .acc_miss(acc_miss), .miss_only(miss_only),
        .hist_mode(hist_mode), .conf_thresh(conf_thresh), .pf_valid(pf_valid),
        .pf_ready(pf_ready), .pf_addr(pf_addr)
    );

    // fields: addr[52:37] miss[36] thresh[35:34] count[33:32] first[31:16] second[15:0]
    localparam logic [52:0] VEC [13] = '{
        {16'h0010, 1'b1, 2'd1, 2'd0, 16'h0000, 16'h0000}, // R1 empty table
        {16'h0021, 1'b1, 2'd1, 2'd0, 16'h0000, 16'h0000}, // R3 alloc entry A
        {16'h0010, 1'b1, 2'd1, 2'd1, 16'h0021, 16'h0000}, // R2 R7 lookup A
        {16'h0021, 1'b1, 2'd1, 2'd1, 16'h0010, 16'h0000},
        {16'h0010, 1'b1, 2'd1, 2'd1, 16'h0021, 16'h0000}, // R4 B conf 2
        {16'h0032, 1'b1, 2'd1, 2'd0, 16'h0000, 16'h0000}, // R5 C into empty slot
        {16'h0010, 1'b1, 2'd1, 2'd2, 16'h0021, 16'h0032}, // R7 order B then C
        {16'h0032, 1'b1, 2'd1, 2'd1, 16'h0010, 16'h0000}, // R4 C up, B down
        {16'h0010, 1'b1, 2'd1, 2'd2, 16'h0032, 16'h0021}, // R7 order C then B
        {16'h0010, 1'b1, 2'd2, 2'd1, 16'h0032, 16'h0000}, // R5 R7 threshold 2
        {16'h0048, 1'b1, 2'd1, 2'd0, 16'h0000, 16'h0000}, // R2 same index other tag
        {16'h0021, 1'b1, 2'd1, 2'd1, 16'h0010, 16'h0000}, // R6 realloc idx 0
        {16'h0010, 1'b1, 2'd1, 2'd0, 16'h0000, 16'h0000}  // R6 A evicted
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(negedge clk) begin
        if (pf_valid && pf_ready) begin
            if (n_got < 8) got[n_got] = pf_addr;
            n_got++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 50000 cycles", cyc);
            summary();
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pf_valid after reset", 32'(pf_valid), 32'd0);
        check("R1 acc_ready after reset", 32'(acc_ready), 32'd1);
    endtask

    task automatic send(input logic [15:0] a, input logic m, input bit busy);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr  = a;
        acc_miss  = m;
        n_got     = 0;
        @(negedge clk);
        acc_valid = 1'b0;
        if (busy) check("R11 busy after accept", 32'(acc_ready), 32'd0);
        else      check("R9 filtered keeps ready", 32'(acc_ready), 32'd1);
        while (!acc_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        do_reset();

        // table walk: R2..R7
        for (int v = 0; v < 13; v++) begin
            logic [52:0] e;
            e = VEC[v];
            conf_thresh = e[35:34];
            send(e[52:37], e[36], 1'b1);
            check($sformatf("R7 vec %0d count", v), 32'(n_got), 32'(e[33:32]));
            if (e[33:32] >= 2'd1) check($sformatf("R7 vec %0d first", v), 32'(got[0]), 32'(e[31:16]));
            if (e[33:32] >= 2'd2) check($sformatf("R7 vec %0d second", v), 32'(got[1]), 32'(e[15:0]));
        end

        // R9: filtered access ignored, history kept
        conf_thresh = 2'd1;
        miss_only   = 1'b1;
        send(16'h0021, 1'b0, 1'b0);
        check("R9 filtered gives no prefetch", 32'(n_got), 32'd0);
        send(16'h0010, 1'b1, 1'b1);
        check("R9 kept miss count", 32'(n_got), 32'd1);
        check("R9 kept miss addr", 32'(got[0]), 32'h0010);
        miss_only = 1'b0;

        // R10: stalled consumer, queue fills, extras dropped
        pf_ready = 1'b0;
        for (int k = 0; k < 6; k++) send(16'h0010, 1'b1, 1'b1);
        check("R10 valid while stalled", 32'(pf_valid), 32'd1);
        check("R10 head addr", 32'(pf_addr), 32'h0010);
        n_got = 0;
        pf_ready = 1'b1;
        repeat (8) @(negedge clk);
        check("R10 drained count", 32'(n_got), 32'd4);

        // R4: confidence saturates at 3
        conf_thresh = 2'd3;
        send(16'h0010, 1'b1, 1'b1);
        check("R4 saturated count", 32'(n_got), 32'd1);

        // R8: history mode, also R1 table cleared by reset
        do_reset();
        hist_mode   = 1'b1;
        conf_thresh = 2'd1;
        send(16'h0101, 1'b1, 1'b1);
        check("R8 first", 32'(n_got), 32'd0);
        send(16'h0202, 1'b1, 1'b1);
        check("R8 second", 32'(n_got), 32'd0);
        send(16'h0303, 1'b1, 1'b1);
        check("R8 xor key count", 32'(n_got), 32'd1);
        check("R8 xor key addr", 32'(got[0]), 32'h0202);

        summary();
        $finish;
    end

endmodule